// File: doc/BRIEF.md
# Long-Format Multi-Level Page Table Walker

The walker translates one virtual address by reading 64-bit page-table descriptors from memory, one level at a time. It supports 4 KB, 16 KB and 64 KB translation granules and table levels 0 to 3. A walk starts at a level and a table base that the requester gives. At each level the walker builds a descriptor address from the current table base and a slice of the virtual address. It then classifies the returned descriptor by its low bits, the current level and the granule. Table descriptors move the walk one level down. Block and page descriptors end it.

Permission limits found in table descriptors are gathered along the way and applied on top of the final entry's own bits. The requester gets a one-cycle completion pulse that carries one of three things: the physical address, the mapping size and the merged attributes; a translation fault; or an address-size or access-flag fault. The completion also reports the level at which the walk stopped.

The memory side is a simple request/valid pair. The walker holds its request and address steady until a read result comes back.

Top module: `ld_page_walker`

## Requirements
- R1: The low bits of a descriptor decide its kind. Code 11 is a table at levels 0 to 2 and a page at level 3. Code 01 is a block at levels 1 and 2 with the 4 KB granule, and at level 2 only with the 16 KB and 64 KB granules. Every other combination ends the walk with fault code 1 (translation).
- R2: The descriptor address equals the table base with bits [2:0] cleared, ORed with a VA index shifted left by 3. The index is (g-3) bits wide and starts at bit (g-3)*(3-level)+g, where g is 12, 14 or 16 for granule codes 0, 1 and 2. A table descriptor supplies the next base as bits [47:g] with the low g bits cleared.
- R3: On success, out_pa takes descriptor bits [47:n] and VA bits [n-1:0], where n is the offset width.
- R4: out_size reports n. For a page, n = g. For a block, n is 30 at level 1 and 21 at level 2 with the 4 KB granule, 25 with 16 KB and 29 with 64 KB.
- R5: Table bits accumulate as sticky ORs over the walk. These bits are 63 (non-secure), 62 (no write), 61 (no unprivileged access), 60 (no execute) and 59 (no privileged execute). Outputs: out_xn = leaf bit 54 | acc; out_pxn = leaf bit 53 | acc; out_ap = {leaf bit 7 | no-write, leaf bit 6 & ~no-unpriv}; out_ns = leaf bit 5 | acc. Also out_contig = bit 52, out_sh = [9:8] and out_attr = [4:2].
- R6: out_ng equals leaf bit 11 when hi_priv is 0, and is forced to 0 when hi_priv is 1.
- R7: A leaf with bit 10 (access flag) at 0 and no address-size fault ends with fault code 2, out_pa 0 and all attributes 0.
- R8: If a next table base or a leaf output address has any bit set at or above pa_bits, the walk ends with fault code 3. This check takes priority over the access flag.
- R9: done is a single-cycle pulse, and end_lvl gives the level of the descriptor that ended the walk. A start asserted while busy is ignored.
- R10: After reset, done, busy and rd_req are 0.
- R11: Granule code 3 ends the walk on the cycle after start, with fault code 1 at the start level and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | VA_W | Virtual address to translate |
| tbl_base | input | PA_W | Base of the first table |
| start_lvl | input | 2 | Level of the first table |
| gran | input | 2 | Granule: 0=4 KB, 1=16 KB, 2=64 KB |
| hi_priv | input | 1 | Walk for a top privilege level (all global) |
| pa_bits | input | 6 | Configured physical address width |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Descriptor read request, held until rd_valid |
| rd_addr | output | PA_W | Descriptor address |
| rd_valid | input | 1 | Read data present |
| rd_data | input | 64 | Descriptor read |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 2 | 0 none, 1 translation, 2 access flag, 3 address size |
| end_lvl | output | 2 | Level where the walk stopped |
| out_pa | output | PA_W | Translated physical address |
| out_size | output | 5 | Offset width of the mapping |
| out_xn | output | 1 | Execute never (merged) |
| out_pxn | output | 1 | Privileged execute never (merged) |
| out_ap | output | 2 | {read-only, unprivileged access} (merged) |
| out_ns | output | 1 | Non-secure output (merged) |
| out_ng | output | 1 | Non-global |
| out_sh | output | 2 | Shareability |
| out_attr | output | 3 | Attribute index |
| out_contig | output | 1 | Contiguous hint |

## Verification
The bench uses the default widths of 48 physical and 48 virtual bits. That width lets the random walks reach every level of all three granules, including the single high index bit that a 16 KB walk starting at level 0 uses. Configured address widths are drawn from 32 to 48 bits. The random table bases sometimes set bits 40 to 47, so address-size faults appear on both table and leaf steps. A sparse descriptor memory and a 0 to 2 cycle read latency exercise the held request across real waits.

// File: rtl/ld_page_walker.sv
module ld_page_walker #(
  parameter int PA_W = 48,
  parameter int VA_W = 48
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] tbl_base,
  input  logic [1:0]      start_lvl,
  input  logic [1:0]      gran,
  input  logic            hi_priv,
  input  logic [5:0]      pa_bits,
  output logic            busy,
  output logic            rd_req,
  output logic [PA_W-1:0] rd_addr,
  input  logic            rd_valid,
  input  logic [63:0]     rd_data,
  output logic            done,
  output logic [1:0]      fault,
  output logic [1:0]      end_lvl,
  output logic [PA_W-1:0] out_pa,
  output logic [4:0]      out_size,
  output logic            out_xn,
  output logic            out_pxn,
  output logic [1:0]      out_ap,
  output logic            out_ns,
  output logic            out_ng,
  output logic [1:0]      out_sh,
  output logic [2:0]      out_attr,
  output logic            out_contig
);
  localparam logic [1:0] F_NONE  = 2'd0;
  localparam logic [1:0] F_TRANS = 2'd1;
  localparam logic [1:0] F_AFLAG = 2'd2;
  localparam logic [1:0] F_ASIZE = 2'd3;

  typedef enum logic {S_IDLE, S_FETCH} st_t;
  st_t st;

  logic [VA_W-1:0] va_r;
  logic [PA_W-1:0] base_r;
  logic [1:0]      lvl_r, gran_r;
  logic [5:0]      pab_r;
  logic            hp_r;
  logic            acc_xn, acc_pxn, acc_nw, acc_nu, acc_ns;

  logic [4:0]  gw, stride, leaf_n;
  logic [6:0]  idx_lo;
  logic [63:0] va64, idx, desc_ptr, tbl_next, lo_mask, leaf_pa;
  logic        is_tbl, is_page, is_blk, tbl_big, leaf_big, step_tbl;
  logic        fin;
  logic [1:0]  fin_code, fin_lvl;

  always_comb begin
    gw       = (gran_r == 2'd0) ? 5'd12 : (gran_r == 2'd1) ? 5'd14 : 5'd16;
    stride   = gw - 5'd3;
    idx_lo   = 7'(stride) * 7'(2'd3 - lvl_r) + 7'(gw);
    va64     = 64'(va_r);
    idx      = (va64 >> idx_lo) & ((64'd1 << stride) - 64'd1);
    desc_ptr = (64'(base_r) & ~64'd7) | (idx << 3);
    tbl_next = 64'(rd_data[PA_W-1:0]) & ~((64'd1 << gw) - 64'd1);
    tbl_big  = (tbl_next >> pab_r) != 64'd0;
  end

  assign is_tbl  = rd_data[1:0] == 2'b11 && lvl_r != 2'd3;
  assign is_page = rd_data[1:0] == 2'b11 && lvl_r == 2'd3;
  assign is_blk  = rd_data[1:0] == 2'b01 &&
                   ((gran_r == 2'd0) ? (lvl_r == 2'd1 || lvl_r == 2'd2) : (lvl_r == 2'd2));

  always_comb begin
    if (is_page)             leaf_n = gw;
    else if (gran_r == 2'd0) leaf_n = (lvl_r == 2'd1) ? 5'd30 : 5'd21;
    else if (gran_r == 2'd1) leaf_n = 5'd25;
    else                     leaf_n = 5'd29;
    lo_mask  = (64'd1 << leaf_n) - 64'd1;
    leaf_pa  = (64'(rd_data[PA_W-1:0]) & ~lo_mask) | (va64 & lo_mask);
    leaf_big = (leaf_pa >> pab_r) != 64'd0;
  end

  assign step_tbl = is_tbl && !tbl_big;

  always_comb begin
    fin      = 1'b0;
    fin_code = F_TRANS;
    fin_lvl  = lvl_r;
    if (st == S_IDLE) begin
      fin     = start && gran == 2'd3;
      fin_lvl = start_lvl;
    end else if (rd_valid && !step_tbl) begin
      fin = 1'b1;
      if (is_tbl)                 fin_code = F_ASIZE;
      else if (is_page || is_blk) fin_code = leaf_big ? F_ASIZE : (!rd_data[10] ? F_AFLAG : F_NONE);
    end
  end

  assign busy    = st == S_FETCH;
  assign rd_req  = st == S_FETCH;
  assign rd_addr = desc_ptr[PA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_r <= '0; base_r <= '0; lvl_r <= '0; gran_r <= '0; pab_r <= '0; hp_r <= 1'b0;
      {acc_xn, acc_pxn, acc_nw, acc_nu, acc_ns} <= '0;
    end else if (st == S_IDLE) begin
      if (start) begin
        va_r   <= va;
        base_r <= tbl_base;
        lvl_r  <= start_lvl;
        gran_r <= gran;
        pab_r  <= pa_bits;
        hp_r   <= hi_priv;
        {acc_xn, acc_pxn, acc_nw, acc_nu, acc_ns} <= '0;
        if (gran != 2'd3) st <= S_FETCH;
      end
    end else if (rd_valid) begin
      if (step_tbl) begin
        base_r  <= tbl_next[PA_W-1:0];
        lvl_r   <= lvl_r + 2'd1;
        acc_ns  <= acc_ns  | rd_data[63];
        acc_nw  <= acc_nw  | rd_data[62];
        acc_nu  <= acc_nu  | rd_data[61];
        acc_xn  <= acc_xn  | rd_data[60];
        acc_pxn <= acc_pxn | rd_data[59];
      end else begin
        st <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; fault <= F_NONE; end_lvl <= '0; out_pa <= '0; out_size <= '0;
      {out_xn, out_pxn, out_ap, out_ns, out_ng, out_sh, out_attr, out_contig} <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        fault   <= fin_code;
        end_lvl <= fin_lvl;
        if (fin_code == F_NONE) begin
          out_pa     <= leaf_pa[PA_W-1:0];
          out_size   <= leaf_n;
          out_xn     <= rd_data[54] | acc_xn;
          out_pxn    <= rd_data[53] | acc_pxn;
          out_ap     <= {rd_data[7] | acc_nw, rd_data[6] & ~acc_nu};
          out_ns     <= rd_data[5] | acc_ns;
          out_ng     <= hp_r ? 1'b0 : rd_data[11];
          out_sh     <= rd_data[9:8];
          out_attr   <= rd_data[4:2];
          out_contig <= rd_data[52];
        end else begin
          out_pa   <= '0;
          out_size <= '0;
          {out_xn, out_pxn, out_ap, out_ns, out_ng, out_sh, out_attr, out_contig} <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ld_page_walker_chk.sv
module ld_page_walker_chk #(
  parameter int PA_W = 48
)(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rd_req,
  input logic            rd_valid,
  input logic [PA_W-1:0] rd_addr,
  input logic            done,
  input logic [1:0]      fault,
  input logic [PA_W-1:0] out_pa,
  input logic [4:0]      out_size
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_req);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  p_size_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd0 |-> out_size >= 5'd12 && out_size <= 5'd30);

  p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 2'd0 |-> out_pa == '0 && out_size == 5'd0);

  p_req_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
endmodule

bind ld_page_walker ld_page_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_addr(rd_addr), .done(done), .fault(fault), .out_pa(out_pa), .out_size(out_size)
);

// File: tb/ld_page_walker_tb.sv
module ld_page_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 48;
  localparam int VA_W = 48;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [VA_W-1:0] va = '0;
  logic [PA_W-1:0] tbl_base = '0;
  logic [1:0] start_lvl = '0, gran = '0;
  logic hi_priv = 0;
  logic [5:0] pa_bits = 6'd48;
  logic busy, rd_req, rd_valid = 0, done;
  logic [PA_W-1:0] rd_addr, out_pa;
  logic [63:0] rd_data = '0;
  logic [1:0] fault, end_lvl, out_ap, out_sh;
  logic [4:0] out_size;
  logic out_xn, out_pxn, out_ns, out_ng, out_contig;
  logic [2:0] out_attr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_page_walker #(.PA_W(PA_W), .VA_W(VA_W)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [63:0]];

  logic [63:0] b_va, b_base;
  int b_lvl, b_gran, b_pab;
  bit b_hp;

  int e_fault, e_lvl, e_size, e_nrd;
  logic [63:0] e_pa;
  logic [11:0] e_attr;
  logic [63:0] e_addr [4];
  int nrd;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gw_of(int g);
    return g == 0 ? 12 : g == 1 ? 14 : 16;
  endfunction

  function automatic logic [63:0] daddr(int g, int lvl, logic [63:0] v, logic [63:0] base);
    int w = gw_of(g);
    int s = w - 3;
    int lo = s * (3 - lvl) + w;
    logic [63:0] ix = (v >> lo) & ((64'd1 << s) - 1);
    return (base & ~64'd7) | (ix << 3);
  endfunction

  task automatic model();
    int w = gw_of(b_gran);
    int lvl = b_lvl;
    logic [63:0] base = b_base;
    bit axn = 0, apxn = 0, anw = 0, anu = 0, ans = 0;
    bit fin = 0;
    e_nrd = 0; e_pa = 0; e_size = 0; e_attr = 0;
    if (b_gran == 3) begin
      e_fault = 1; e_lvl = b_lvl; return;
    end
    while (!fin) begin
      logic [63:0] a = daddr(b_gran, lvl, b_va, base);
      logic [63:0] d = mem.exists(a) ? mem[a] : 64'd0;
      bit leaf;
      e_addr[e_nrd] = a; e_nrd++;
      leaf = (d[1:0] == 2'b11 && lvl == 3) ||
             (d[1:0] == 2'b01 && (b_gran == 0 ? (lvl == 1 || lvl == 2) : lvl == 2));
      e_lvl = lvl;
      if (d[1:0] == 2'b11 && lvl < 3) begin
        logic [63:0] nb = {16'd0, d[47:0]} & ~((64'd1 << w) - 1);
        if ((nb >> b_pab) != 0) begin e_fault = 3; fin = 1; end
        else begin
          ans |= d[63]; anw |= d[62]; anu |= d[61]; axn |= d[60]; apxn |= d[59];
          base = nb; lvl++;
        end
      end else if (!leaf) begin
        e_fault = 1; fin = 1;
      end else begin
        int n = (lvl == 3) ? w : (b_gran == 0 ? (lvl == 1 ? 30 : 21) : (b_gran == 1 ? 25 : 29));
        logic [63:0] m = (64'd1 << n) - 1;
        logic [63:0] pa = ({16'd0, d[47:0]} & ~m) | (b_va & m);
        fin = 1;
        if ((pa >> b_pab) != 0) e_fault = 3;
        else if (!d[10]) e_fault = 2;
        else begin
          e_fault = 0; e_pa = pa; e_size = n;
          e_attr = {d[54] | axn, d[53] | apxn, d[7] | anw, d[6] & ~anu, d[5] | ans,
                    b_hp ? 1'b0 : d[11], d[9:8], d[4:2], d[52]};
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (nrd < 4) chk("R2 desc addr", 64'(rd_addr), e_addr[nrd]);
        else chk("R2 read count", 64'(nrd), 64'(e_nrd));
        nrd++;
        rd_data = mem.exists(64'(rd_addr)) ? mem[64'(rd_addr)] : 64'd0;
        rd_valid = 1;
        @(negedge clk);
        rd_valid = 0;
      end
    end
  end

  task automatic run_walk(bit disturb);
    model();
    nrd = 0;
    @(negedge clk);
    va = b_va[VA_W-1:0]; tbl_base = b_base[PA_W-1:0]; start_lvl = 2'(b_lvl);
    gran = 2'(b_gran); hi_priv = b_hp; pa_bits = 6'(b_pab);
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      va = ~b_va[VA_W-1:0]; start_lvl = 2'(b_lvl + 1); start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk("R1 fault", 64'(fault), 64'(e_fault));
    chk("R9 end level", 64'(end_lvl), 64'(e_lvl));
    chk("R3 pa", 64'(out_pa), e_pa);
    chk("R4 size", 64'(out_size), 64'(e_size));
    chk("R5 attrs", 64'({out_xn, out_pxn, out_ap, out_ns, out_ng, out_sh, out_attr, out_contig}), 64'(e_attr));
    chk("R2 reads", 64'(nrd), 64'(e_nrd));
    @(negedge clk);
    chk("R9 pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] rbase();
    logic [63:0] v = 64'($urandom) & 64'hFFFF_0000;
    if ($urandom % 10 == 0) v |= 64'd1 << (40 + $urandom % 8);
    return v;
  endfunction

  function automatic logic [63:0] mk_leaf(int kind, bit af);
    logic [63:0] oa = {16'd0, 16'($urandom), 32'($urandom)};
    logic [63:0] d;
    if ($urandom % 6 != 0) oa &= (64'd1 << b_pab) - 1;
    d = {9'd0, 3'($urandom), 4'd0, oa[47:0]};
    d[10] = af;
    d[1:0] = 2'(kind);
    return d;
  endfunction

  task automatic build_random();
    logic [63:0] base;
    mem.delete();
    b_gran = $urandom % 3; b_lvl = $urandom % 4; b_hp = ($urandom % 4) == 0;
    b_pab = 32 + 4 * ($urandom % 5);
    b_va = {16'd0, 16'($urandom), 32'($urandom)};
    b_base = rbase(); base = b_base;
    for (int l = b_lvl; l < 4; l++) begin
      int r = $urandom % 10;
      logic [63:0] a = daddr(b_gran, l, b_va, base);
      bit af = ($urandom % 8) != 0;
      if (l < 3 && r < 5) begin
        logic [63:0] nb = rbase();
        logic [4:0] rs = 5'($urandom) & 5'($urandom);
        mem[a] = {rs, 11'd0, nb[47:0]} | 64'd3;
        base = nb;
      end else if (l < 3) mem[a] = mk_leaf(r < 8 ? 1 : (r == 8 ? 0 : 2), af);
      else mem[a] = mk_leaf(r < 8 ? 3 : (r == 8 ? 1 : 0), af);
    end
  endtask

  task automatic one_leaf(int g, int lvl, logic [63:0] d, bit hp, int pab);
    mem.delete();
    b_gran = g; b_lvl = lvl; b_hp = hp; b_pab = pab;
    b_va = 64'h0000_5A5A_1234_5678; b_base = 64'h0000_0000_0030_0000;
    if (g != 3) mem[daddr(g, lvl, b_va, b_base)] = d;
    run_walk(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    #(CLK_PERIOD * 2 + 1);
    chk("R10 done at reset", 64'(done), 0);
    chk("R10 busy at reset", 64'(busy), 0);
    chk("R10 rd_req at reset", 64'(rd_req), 0);
    rst_n = 1;

    one_leaf(0, 1, 64'h0000_00AB_C000_0401, 0, 48);
    chk("R4 4K L1 block", 64'(out_size), 30);
    one_leaf(0, 2, 64'h0000_00AB_C020_0401, 0, 48);
    chk("R4 4K L2 block", 64'(out_size), 21);
    one_leaf(1, 2, 64'h0000_00AB_C200_0401, 0, 48);
    chk("R4 16K L2 block", 64'(out_size), 25);
    one_leaf(2, 2, 64'h0000_00A0_0000_0401, 0, 48);
    chk("R4 64K L2 block", 64'(out_size), 29);
    one_leaf(2, 3, 64'h0000_00AB_C001_0403, 0, 48);
    chk("R4 64K page", 64'(out_size), 16);
    chk("R3 64K page pa", 64'(out_pa), 64'h0000_00AB_C001_5678);
    one_leaf(0, 0, 64'h0000_00AB_C000_0401, 0, 48);
    chk("R1 block at L0 4K", 64'(fault), 1);
    one_leaf(1, 1, 64'h0000_00AB_C000_0401, 0, 48);
    chk("R1 block at L1 16K", 64'(fault), 1);
    one_leaf(0, 3, 64'h0000_00AB_C000_0C03, 1, 48);
    chk("R6 high privilege global", 64'(out_ng), 0);
    one_leaf(0, 3, 64'h0000_00AB_C000_0C03, 0, 48);
    chk("R6 non-global kept", 64'(out_ng), 1);
    one_leaf(0, 3, 64'h0000_00AB_C000_0003, 0, 48);
    chk("R7 access flag fault", 64'(fault), 2);
    one_leaf(0, 3, 64'h0000_010B_C000_0003, 0, 40);
    chk("R8 size beats access flag", 64'(fault), 3);
    one_leaf(3, 1, 64'd0, 0, 48);
    chk("R11 bad granule", 64'(fault), 1);
    chk("R11 no read", 64'(nrd), 0);

    mem.delete();
    b_gran = 0; b_lvl = 2; b_hp = 0; b_pab = 48;
    b_va = 64'h0000_0000_4020_3ABC; b_base = 64'h0000_0000_0010_0000;
    mem[daddr(0, 2, b_va, b_base)] = 64'hF800_0000_0020_0003;
    mem[daddr(0, 3, b_va, 64'h20_0000)] = 64'h0000_0000_7777_7443;
    run_walk(1);
    chk("R5 merged xn/pxn", 64'({out_xn, out_pxn}), 64'b11);
    chk("R5 merged ap", 64'(out_ap), 64'b10);
    chk("R5 merged ns", 64'(out_ns), 1);
    chk("R9 ignored start level", 64'(end_lvl), 3);

    for (int i = 0; i < 600; i++) begin
      build_random();
      run_walk(i % 7 == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule